// File: doc/BRIEF.md
# Up/Down Timer with Reload and Capture

A timer/counter whose width is a parameter (16 bits by default), paired with a register of the same width that holds either a reload value or a captured count. The count advances once per machine-cycle tick in timer function. In counter function it advances once per falling edge seen on the count pin. A trigger pin can start a reload, take a capture or raise a separate external flag, depending on the mode. With up/down counting enabled, the level of the trigger pin also sets the count direction.

There are three operating modes. Auto-reload loads the reload value whenever the count overflows. Capture copies the running count into the capture register on a trigger edge. Baud generation produces a one-clock overflow pulse for a serial port's bit timing. The host sets the mode and writes the byte-wide count and reload registers through a simple write port. The overflow flag, the external flag, the count, the reload/capture value, the baud pulse and a clock-output enable are all presented on output ports.

Top module: `cap_reload_timer`

## Requirements
- R1: While reset is low, the count, the reload/capture value, both flags, the baud pulse and the clock-output enable are all 0.
- R2: In timer function (run=1, counter select=0), the count rises by exactly 1 on each clock that has `tick` high, and it does not change on clocks without `tick`.
- R3: In counter function (counter select=1), the count pin is sampled on every tick. A high sample followed by a low sample makes the count advance on the next tick. A pin held low gives no further steps.
- R4: In auto-reload mode (capture select=0, both clock selects=0, up/down off), a step from all-ones loads the reload value into the count and sets the overflow flag.
- R5: In auto-reload mode with external enable=1 and up/down off, a trigger falling edge (detected the same way as in R3) loads the reload value and sets the external flag. This load wins over a simultaneous count step.
- R6: With up/down enable (mode bit 0) set in auto-reload mode, a sampled high trigger level counts up and a sampled low level counts down. A down step from a count equal to the reload value loads all-ones. Both wraps set the overflow flag and toggle the external flag.
- R7: In capture mode (capture select=1), the count only goes up and wraps from all-ones to 0, setting the overflow flag. With external enable=1, a trigger falling edge copies the pre-step count into the capture register and sets the external flag.
- R8: When either clock select is 1, an overflow reloads the count and drives `baud_tick` high for one clock, without setting the overflow flag. A trigger edge only sets the external flag and leaves the count alone.
- R9: With run=0 and external enable=0, the count holds in every mode.
- R10: A host write to a count or reload byte takes that byte from `wr_data` and holds the other bytes, overriding any hardware update of that register in the same clock. A control write overrides hardware flag updates.
- R11: Address map: 0 control, 1 mode, 2 and up the reload bytes (lowest byte first), then the count bytes. Control bits 7..0 are overflow flag, external flag, receive-clock select, transmit-clock select, external enable, run, counter select, capture select. Software may write the flags. Mode bit 1 drives `clkout_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Machine-cycle enable, one clock wide |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger / direction input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count_val | output | 16 | Current count |
| rcap_val | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| baud_tick | output | 1 | One-clock pulse per overflow in baud mode |
| clkout_en | output | 1 | Clock-output enable from the mode register |

## Verification
Some properties are checked on every clock: write priority over count and reload bytes, and the count holding while stopped. Others are the link between a rising overflow flag and the reloaded count in auto-reload mode, a rising external flag and the captured count in capture mode, and the unchanged overflow flag on a baud pulse. Some behaviour needs scripted scenarios. This covers the two-tick latency of edge detection on both pins, the direction taken from the trigger level, and the down-count wrap to all-ones at the reload value. It also covers the external flag toggling on wraps, the capture mode's wrap to zero, and the exact cycle of the baud pulse.

// File: rtl/crt_pkg.sv
package crt_pkg;

   // control register bit positions (decoded by the flag and mode logic)
   localparam int CTL_OVF  = 7;
   localparam int CTL_EXT  = 6;
   localparam int CTL_RCLK = 5;
   localparam int CTL_TCLK = 4;
   localparam int CTL_EXEN = 3;
   localparam int CTL_RUN  = 2;
   localparam int CTL_CT   = 1;
   localparam int CTL_CPRL = 0;

   // mode register bit positions
   localparam int MOD_OE   = 1;
   localparam int MOD_DCEN = 0;

   // fixed register addresses; reload and count blocks follow
   localparam int ADR_CTRL = 0;
   localparam int ADR_MODE = 1;
   localparam int ADR_RLD  = 2;

   typedef enum logic [1:0] {
      OPM_RELOAD  = 2'd0,
      OPM_CAPTURE = 2'd1,
      OPM_BAUD    = 2'd2
   } op_mode_e;

   typedef struct packed {
      logic run;
      logic ct_sel;
      logic exen;
      logic updn;
      op_mode_e opm;
   } cfg_t;

   typedef struct packed {
      logic ovf_set;
      logic ext_set;
      logic ext_tgl;
   } flag_evt_t;

endpackage

// File: rtl/crt_pin_sampler.sv
module crt_pin_sampler #(
   parameter int NPINS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [NPINS-1:0] pins,
   output logic [NPINS-1:0] level,
   output logic [NPINS-1:0] fall
);

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         logic s_now, s_prev;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_now  <= 1'b0;
               s_prev <= 1'b0;
            end else if (tick) begin
               s_prev <= s_now;
               s_now  <= pins[p];
            end
         end

         assign level[p] = s_now;
         assign fall[p]  = s_prev & ~s_now;
      end
   endgenerate

endmodule

// File: rtl/crt_regs.sv
module crt_regs #(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [BUS_W-1:0]   wr_data,
   input  crt_pkg::flag_evt_t evt,
   output logic [7:0]         ctrl_q,
   output logic               oe_q,
   output logic               dcen_q,
   output crt_pkg::cfg_t      cfg
);
   import crt_pkg::*;

   logic ctrl_wr, mode_wr;
   logic baud_sel;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
   assign mode_wr = wr_en && (wr_addr == ADDR_W'(ADR_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= wr_data[7:0];
      end else begin
         if (evt.ovf_set)
            ctrl_q[CTL_OVF] <= 1'b1;
         if (evt.ext_set)
            ctrl_q[CTL_EXT] <= 1'b1;
         else if (evt.ext_tgl)
            ctrl_q[CTL_EXT] <= ~ctrl_q[CTL_EXT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         dcen_q <= 1'b0;
      end else if (mode_wr) begin
         oe_q   <= wr_data[MOD_OE];
         dcen_q <= wr_data[MOD_DCEN];
      end
   end

   assign baud_sel = ctrl_q[CTL_RCLK] | ctrl_q[CTL_TCLK];

   always_comb begin
      cfg.run    = ctrl_q[CTL_RUN];
      cfg.ct_sel = ctrl_q[CTL_CT];
      cfg.exen   = ctrl_q[CTL_EXEN];
      if (baud_sel)
         cfg.opm = OPM_BAUD;
      else if (ctrl_q[CTL_CPRL])
         cfg.opm = OPM_CAPTURE;
      else
         cfg.opm = OPM_RELOAD;
      cfg.updn = dcen_q && (cfg.opm == OPM_RELOAD);
   end

endmodule

// File: rtl/crt_core.sv
module crt_core #(
   parameter int CNT_W    = 16,
   parameter int BUS_W    = 8,
   parameter int ADDR_W   = 3,
   parameter int RLD_BASE = 2,
   parameter int CNT_BASE = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [BUS_W-1:0]   wr_data,
   input  crt_pkg::cfg_t      cfg,
   input  logic               cnt_fall,
   input  logic               trig_fall,
   input  logic               trig_lvl,
   output logic [CNT_W-1:0]   count_q,
   output logic [CNT_W-1:0]   rcap_q,
   output crt_pkg::flag_evt_t evt,
   output logic               baud_tick
);
   import crt_pkg::*;

   localparam int NBYTES = CNT_W / BUS_W;

   logic [NBYTES-1:0] cnt_wr, rld_wr;
   logic [CNT_W-1:0]  cnt_sw, rld_sw;
   logic [CNT_W-1:0]  cnt_hw, cnt_d, rld_d;
   logic step_en, trig_ev, up_dir, at_max, at_floor, wrap_up, wrap_dn;
   logic capt_ev;

   // byte lanes of the host write path
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         assign cnt_wr[b] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + b));
         assign rld_wr[b] = wr_en && (wr_addr == ADDR_W'(RLD_BASE + b));
         assign cnt_sw[b*BUS_W +: BUS_W] = cnt_wr[b] ? wr_data : count_q[b*BUS_W +: BUS_W];
         assign rld_sw[b*BUS_W +: BUS_W] = rld_wr[b] ? wr_data : rcap_q[b*BUS_W +: BUS_W];
      end
   endgenerate

   // step qualification
   assign step_en  = tick && cfg.run && (cfg.ct_sel ? cnt_fall : 1'b1);
   assign trig_ev  = tick && cfg.exen && trig_fall;
   assign up_dir   = !cfg.updn || trig_lvl;
   assign at_max   = (count_q == {CNT_W{1'b1}});
   assign at_floor = (count_q == rcap_q);
   assign wrap_up  = step_en && up_dir && at_max;
   assign wrap_dn  = step_en && !up_dir && at_floor;
   assign capt_ev  = trig_ev && (cfg.opm == OPM_CAPTURE);

   // hardware next count
   always_comb begin
      cnt_hw = count_q;
      if (step_en) begin
         if (up_dir) begin
            if (at_max)
               cnt_hw = (cfg.opm == OPM_CAPTURE) ? '0 : rcap_q;
            else
               cnt_hw = count_q + 1'b1;
         end else begin
            if (at_floor)
               cnt_hw = {CNT_W{1'b1}};
            else
               cnt_hw = count_q - 1'b1;
         end
      end
      if (trig_ev && (cfg.opm == OPM_RELOAD) && !cfg.updn)
         cnt_hw = rcap_q;
   end

   // host writes take priority over hardware updates
   assign cnt_d = (|cnt_wr) ? cnt_sw : cnt_hw;
   assign rld_d = (|rld_wr) ? rld_sw : (capt_ev ? count_q : rcap_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         rcap_q    <= '0;
         baud_tick <= 1'b0;
      end else begin
         count_q   <= cnt_d;
         rcap_q    <= rld_d;
         baud_tick <= wrap_up && (cfg.opm == OPM_BAUD);
      end
   end

   // flag events toward the control register
   always_comb begin
      evt.ovf_set = (wrap_up || wrap_dn) && (cfg.opm != OPM_BAUD);
      evt.ext_set = trig_ev && !cfg.updn;
      evt.ext_tgl = cfg.updn && (wrap_up || wrap_dn);
   end

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cnt_pin,
   input  logic              trig_pin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_val,
   output logic [CNT_W-1:0]  rcap_val,
   output logic              ovf_flag,
   output logic              ext_flag,
   output logic              baud_tick,
   output logic              clkout_en
);
   import crt_pkg::*;

   localparam int NBYTES   = CNT_W / BUS_W;
   localparam int CNT_BASE = ADR_RLD + NBYTES;
   localparam int LAST_ADR = CNT_BASE + NBYTES - 1;

   generate
      if (BUS_W < 8) begin : g_bad_bus
         $error("BUS_W must hold the 8-bit control register");
      end
      if ((CNT_W % BUS_W) != 0) begin : g_bad_width
         $error("CNT_W must be a whole number of BUS_W bytes");
      end
      if (LAST_ADR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [7:0] ctrl_q;
   logic       oe_q, dcen_q;
   cfg_t       cfg;
   flag_evt_t  evt;
   logic [1:0] pin_lvl, pin_fall;

   crt_pin_sampler #(.NPINS(2)) u_samp (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .pins  ({trig_pin, cnt_pin}),
      .level (pin_lvl),
      .fall  (pin_fall)
   );

   crt_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .evt     (evt),
      .ctrl_q  (ctrl_q),
      .oe_q    (oe_q),
      .dcen_q  (dcen_q),
      .cfg     (cfg)
   );

   crt_core #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
      .RLD_BASE(ADR_RLD), .CNT_BASE(CNT_BASE)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cfg       (cfg),
      .cnt_fall  (pin_fall[0]),
      .trig_fall (pin_fall[1]),
      .trig_lvl  (pin_lvl[1]),
      .count_q   (count_val),
      .rcap_q    (rcap_val),
      .evt       (evt),
      .baud_tick (baud_tick)
   );

   assign ovf_flag  = ctrl_q[CTL_OVF];
   assign ext_flag  = ctrl_q[CTL_EXT];
   assign clkout_en = oe_q;

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [BUS_W-1:0]  wr_data,
   input logic [7:0]        ctrl_q,
   input logic              dcen_q,
   input logic [CNT_W-1:0]  count_val,
   input logic [CNT_W-1:0]  rcap_val,
   input logic              ovf_flag,
   input logic              ext_flag,
   input logic              baud_tick
);
   import crt_pkg::*;

   localparam int NB       = CNT_W / BUS_W;
   localparam int CNT_BASE = ADR_RLD + NB;

   logic ctrl_wr, cnt_wr, rld_wr, baud_sel, reload_up, capt_mode, stopped;

   assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
   assign cnt_wr    = wr_en && (wr_addr >= ADDR_W'(CNT_BASE)) && (wr_addr < ADDR_W'(CNT_BASE + NB));
   assign rld_wr    = wr_en && (wr_addr >= ADDR_W'(ADR_RLD)) && (wr_addr < ADDR_W'(CNT_BASE));
   assign baud_sel  = ctrl_q[CTL_RCLK] || ctrl_q[CTL_TCLK];
   assign reload_up = !baud_sel && !ctrl_q[CTL_CPRL] && !dcen_q;
   assign capt_mode = !baud_sel && ctrl_q[CTL_CPRL];
   assign stopped   = !ctrl_q[CTL_RUN] && !ctrl_q[CTL_EXEN];

   // R1: everything cleared while reset is held
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (count_val == '0 && rcap_val == '0 && !ovf_flag && !ext_flag && !baud_tick));

   // R4: a fresh overflow flag in auto-reload mode comes with the reload value in the count
   p_ovf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf_flag) && $past(reload_up && !ctrl_wr && !cnt_wr)) |-> count_val == $past(rcap_val));

   // R7: a fresh external flag in capture mode comes with the prior count captured
   p_capture_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ext_flag) && $past(capt_mode && !ctrl_wr && !rld_wr)) |-> rcap_val == $past(count_val));

   // R8: a baud pulse leaves the overflow flag untouched
   p_baud_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && !$past(ctrl_wr)) |-> $stable(ovf_flag));

   // R8: baud pulses only come from baud mode
   p_baud_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> $past(baud_sel));

   // R9: stopped counter holds its value
   p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && stopped && !cnt_wr) |=> $stable(count_val));

   // R10: host byte writes override hardware updates
   p_cpu_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(CNT_BASE)) |=> count_val[BUS_W-1:0] == $past(wr_data));

   p_cpu_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADR_RLD)) |=> rcap_val[BUS_W-1:0] == $past(wr_data));

endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .ctrl_q    (ctrl_q),
   .dcen_q    (dcen_q),
   .count_val (count_val),
   .rcap_val  (rcap_val),
   .ovf_flag  (ovf_flag),
   .ext_flag  (ext_flag),
   .baud_tick (baud_tick)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cnt_pin = 1'b1;
   logic        trig_pin = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] count_val, rcap_val;
   logic        ovf_flag, ext_flag, baud_tick, clkout_en;

   always #10 clk = ~clk;

   cap_reload_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .count_val(count_val), .rcap_val(rcap_val), .ovf_flag(ovf_flag),
      .ext_flag(ext_flag), .baud_tick(baud_tick), .clkout_en(clkout_en)
   );

   localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_RLD = 3'd2, A_CNT = 3'd4;

   typedef struct {
      string       req;
      logic [15:0] cnt;
      logic [15:0] rcap;
      logic        ovf;
      logic        ext;
      logic        baud;
      logic        oe;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [15:0] m_rcap = '0;
   logic        m_ovf = 1'b0, m_ext = 1'b0, m_oe = 1'b0;

   // driver side: push expected state
   task automatic expect_now(input string req, input logic [15:0] c, input logic b);
      exp_t e;
      e.req = req; e.cnt = c; e.rcap = m_rcap; e.ovf = m_ovf;
      e.ext = m_ext; e.baud = b; e.oe = m_oe;
      sb.push_back(e);
   endtask

   // monitor side: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (count_val !== e.cnt || rcap_val !== e.rcap || ovf_flag !== e.ovf ||
                ext_flag !== e.ext || baud_tick !== e.baud || clkout_en !== e.oe) begin
               n_fail++;
               $display("FAIL %s: got cnt=%h rcap=%h ovf=%b ext=%b baud=%b oe=%b, expected cnt=%h rcap=%h ovf=%b ext=%b baud=%b oe=%b",
                        e.req, count_val, rcap_val, ovf_flag, ext_flag, baud_tick, clkout_en,
                        e.cnt, e.rcap, e.ovf, e.ext, e.baud, e.oe);
            end
         end
      end
   end

   task automatic clk1(input logic t);
      tick = t;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic mc();
      clk1(1'b1);
      clk1(1'b0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr16(input logic [2:0] base, input logic [15:0] v);
      wr(base, v[7:0]);
      wr(base + 3'd1, v[15:8]);
   endtask

   task automatic wctl(input logic [7:0] d);
      wr(A_CTRL, d);
      m_ovf = d[7];
      m_ext = d[6];
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_now("R1 reset state", 16'h0000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 timer function
      wctl(8'h04);
      repeat (5) mc();
      expect_now("R2 five ticks", 16'h0005, 1'b0);
      repeat (4) clk1(1'b0);
      expect_now("R2 no tick no step", 16'h0005, 1'b0);

      // R9 stop
      wctl(8'h00);
      repeat (3) mc();
      expect_now("R9 run cleared holds", 16'h0005, 1'b0);

      // R4 auto-reload overflow
      wr16(A_RLD, 16'hFFF0); m_rcap = 16'hFFF0;
      wr16(A_CNT, 16'hFFFE);
      wctl(8'h04);
      mc();
      expect_now("R4 below overflow", 16'hFFFF, 1'b0);
      mc(); m_ovf = 1'b1;
      expect_now("R4 overflow reload", 16'hFFF0, 1'b0);
      wctl(8'h04);
      expect_now("R11 control write clears flag", 16'hFFF0, 1'b0);

      // R10 host write wins over a step in the same clock
      tick = 1'b1; wr_en = 1'b1; wr_addr = A_CNT; wr_data = 8'h12;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      expect_now("R10 write beats step", 16'hFF12, 1'b0);

      // R5 trigger reload
      wctl(8'h0C);
      mc(); mc();
      expect_now("R5 before trigger", 16'hFF14, 1'b0);
      trig_pin = 1'b0;
      mc();
      expect_now("R5 first low sample steps", 16'hFF15, 1'b0);
      mc(); m_ext = 1'b1;
      expect_now("R5 trigger reload", 16'hFFF0, 1'b0);
      trig_pin = 1'b1;

      // R3 counter function
      wctl(8'h06);
      wr16(A_CNT, 16'h0000);
      mc(); mc();
      expect_now("R3 high pin no step", 16'h0000, 1'b0);
      cnt_pin = 1'b0;
      mc();
      expect_now("R3 first low sample", 16'h0000, 1'b0);
      mc();
      expect_now("R3 edge counted", 16'h0001, 1'b0);
      mc();
      expect_now("R3 held low no step", 16'h0001, 1'b0);
      cnt_pin = 1'b1; mc();
      cnt_pin = 1'b0; mc(); mc();
      expect_now("R3 second edge", 16'h0002, 1'b0);
      cnt_pin = 1'b1;

      // R6 up/down counting
      wr(A_MODE, 8'h01);
      wctl(8'h00);
      trig_pin = 1'b0;
      mc(); mc();
      wr16(A_RLD, 16'h0100); m_rcap = 16'h0100;
      wr16(A_CNT, 16'h0102);
      wctl(8'h04);
      mc();
      expect_now("R6 low level counts down", 16'h0101, 1'b0);
      mc();
      expect_now("R6 reach reload value", 16'h0100, 1'b0);
      mc(); m_ovf = 1'b1; m_ext = 1'b1;
      expect_now("R6 underflow to all-ones", 16'hFFFF, 1'b0);
      wctl(8'h00);
      trig_pin = 1'b1;
      mc(); mc();
      wctl(8'h04);
      mc(); m_ovf = 1'b1; m_ext = 1'b1;
      expect_now("R6 high level up wrap toggles ext", 16'h0100, 1'b0);
      wr(A_MODE, 8'h00);

      // R7 capture
      wctl(8'h0D);
      wr16(A_CNT, 16'h1000);
      mc(); mc();
      expect_now("R7 counting up", 16'h1002, 1'b0);
      trig_pin = 1'b0;
      mc(); mc(); m_rcap = 16'h1003; m_ext = 1'b1;
      expect_now("R7 capture of pre-step count", 16'h1004, 1'b0);
      wr16(A_CNT, 16'hFFFF);
      mc(); m_ovf = 1'b1;
      expect_now("R7 wrap to zero", 16'h0000, 1'b0);

      // R8 baud generation
      wctl(8'h2C);
      trig_pin = 1'b1;
      mc();
      wr16(A_RLD, 16'hFFFD); m_rcap = 16'hFFFD;
      wr16(A_CNT, 16'hFFFE);
      mc();
      expect_now("R8 before overflow", 16'hFFFF, 1'b0);
      clk1(1'b1);
      expect_now("R8 baud pulse no ovf flag", 16'hFFFD, 1'b1);
      clk1(1'b0);
      expect_now("R8 pulse one clock", 16'hFFFD, 1'b0);
      trig_pin = 1'b0;
      mc();
      mc(); m_ext = 1'b1;
      expect_now("R8 trigger sets ext only", 16'hFFFF, 1'b0);

      // R9 stop in baud mode
      wctl(8'h20);
      mc(); mc();
      expect_now("R9 baud mode stopped", 16'hFFFF, 1'b0);

      // R11 layout: clock-output enable and software-set flags
      wr(A_MODE, 8'h02); m_oe = 1'b1;
      wctl(8'hC0);
      expect_now("R11 mode bit and flag bits", 16'hFFFF, 1'b0);

      @(negedge clk);
      #5;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule